// File: doc/BRIEF.md
# Decoded Micro-Op Cache

This block keeps the already-decoded micro-ops of hot code so that fetch can skip the slow variable-length decoder. Each entry covers one naturally aligned 32-byte window of code. A lookup presents a fetch address. One cycle later the block either returns every micro-op of that window together with a per-slot valid mask, or it raises a fallback flag that tells fetch to send the window through the legacy decode path.

The decoder writes finished windows through a fill port. It supplies, for each micro-op slot, the payload, the start offset and byte length of the instruction that produced it, and a microcode flag. Some windows are never stored. A window is refused if any of its instructions reaches the final byte of the 32-byte chunk, either by ending on it or by running past it. A window is also refused if any of its instructions is microcoded. Such windows always take the fallback path.

The store is 32 sets of 8 ways, and each way holds up to 6 micro-ops. Replacement within a set uses a binary-tree pseudo-LRU. A single invalidate input empties the whole cache.

Top module: `uop_cache`

## Requirements
- R1: After reset every entry is invalid, all response outputs are 0, and any lookup reports a miss with fallback.
- R2: Address bits [4:0] are the byte offset and are ignored for matching. Bits [9:5] select the set, and bits [31:10] are the tag. Any address inside a stored window hits it.
- R3: A lookup presented in cycle N produces its response in cycle N+1. rsp_valid is 1 exactly when a lookup was presented. When rsp_valid is 1, exactly one of rsp_hit and rsp_fallback is 1. When rsp_valid is 0, both are 0.
- R4: On a hit with a stored count C, rsp_mask has bits [C-1:0] set. Slot s (bits [32s+31:32s]) carries the s-th stored micro-op for s < C, and all other slots are zero. On a miss, rsp_mask and rsp_uops are zero.
- R5: A fill is rejected, and nothing is written, if some active slot satisfies start + len >= 32. That is, the instruction ends on byte 31 or crosses past it.
- R6: A fill is rejected if any active slot has its microcode flag set.
- R7: A fill is rejected if fill_count is 0 or greater than 6, or if an active slot has len 0. Slots with index >= fill_count are ignored.
- R8: A fill to a window that is already present overwrites the way holding it. The next lookup returns the new contents, and no set ever holds two valid ways with the same tag.
- R9: A new window goes to the lowest-numbered invalid way of its set. If the set is full, it goes to the tree pseudo-LRU victim. The tree has 7 node bits, with node n having children 2n+1 and 2n+2 and way w being leaf w+7. The victim walk takes the right child when a bit is 1. A touch sets every node on the way's path to point away from it. Lookup hits and accepted fills both touch, with the hit applied before the fill, and the victim is taken from the state before either touch.
- R10: inv_all clears every valid bit and all recency state in one cycle. A fill in the same cycle is dropped. A lookup in the same cycle reports the contents from before the clear.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill. The filled window hits from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Clear every entry this cycle |
| lu_valid | input | 1 | Lookup request |
| lu_addr | input | 32 | Lookup fetch address |
| fill_valid | input | 1 | Fill request from the decoder |
| fill_addr | input | 32 | Address of the window being filled |
| fill_count | input | 3 | Number of micro-ops in the window (1..6) |
| fill_uops | input | 192 | Six 32-bit micro-op payloads, slot 0 in the low bits |
| fill_start | input | 30 | Per-slot 5-bit start offset of the source instruction |
| fill_len | input | 24 | Per-slot 4-bit byte length of the source instruction |
| fill_ucode | input | 6 | Per-slot microcoded-instruction flag |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Window found |
| rsp_fallback | output | 1 | Window absent, use legacy decode |
| rsp_mask | output | 6 | Per-slot valid mask |
| rsp_uops | output | 192 | Six 32-bit micro-op slots |

## Verification
The bench targets the chunk-edge rule at its exact boundary. An instruction ending on byte 30 must be stored, while one ending on byte 31 or crossing it must not. An off-by-one comparison would either lose hot windows or cache forbidden ones. Bad values placed in slots beyond the count must not cause a rejection, since a screen that ignored the count would refuse good windows. The bench also checks that a refill of a resident window replaces it in place, so that a stale copy never answers. The full-set case exercises the exact pseudo-LRU victim after interleaved hits, where a wrong touch order evicts the recently used way. The clear is tested in the same cycle as a fill and a lookup, and the bench notices a clear that loses to the fill or hides the old contents too early.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam int UC_ADDR_W = 32;
  localparam int UC_SETS   = 32;
  localparam int UC_WAYS   = 8;
  localparam int UC_NSLOT  = 6;
  localparam int UC_UOP_W  = 32;
  localparam int UC_OFS_W  = 5;
  localparam int UC_LEN_W  = 4;

  // Where a fill lands inside its set.
  typedef enum logic [1:0] {
    FS_SAME = 2'd0,
    FS_FREE = 2'd1,
    FS_PLRU = 2'd2
  } fill_src_e;
endpackage

// File: rtl/uc_fill_screen.sv
module uc_fill_screen #(
  parameter int NSLOT = 6,
  parameter int OFS_W = 5,
  parameter int LEN_W = 4,
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0]       cnt,
  input  logic [NSLOT*OFS_W-1:0] start,
  input  logic [NSLOT*LEN_W-1:0] len,
  input  logic [NSLOT-1:0]       ucode,
  output logic                   ok
);
  localparam int WIN = 1 << OFS_W;
  localparam int EW  = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;

  logic [NSLOT-1:0] active;
  logic [NSLOT-1:0] slot_bad;

  // Per-slot screen: edge byte touched, microcoded, or empty length.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [EW-1:0] reach;
    assign active[s]   = (cnt > CNT_W'(s));
    assign reach       = EW'(start[s*OFS_W +: OFS_W]) + EW'(len[s*LEN_W +: LEN_W]);
    assign slot_bad[s] = active[s] &&
                         ((reach >= EW'(WIN)) || ucode[s] || (len[s*LEN_W +: LEN_W] == '0));
  end

  assign ok = (cnt != '0) && (cnt <= CNT_W'(NSLOT)) && (slot_bad == '0);
endmodule

// File: rtl/uc_tag_match.sv
module uc_tag_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 22,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            match,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tags[w] == tag);
  end

  always_comb begin
    hit = |match;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/uc_plru.sv
module uc_plru #(
  parameter int SETS  = 32,
  parameter int WAYS  = 8,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);
  localparam int LVL    = $clog2(WAYS);
  localparam int NODE_W = $clog2(WAYS);

  logic [WAYS-2:0] st_q [SETS];

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] b, input logic [WAY_W-1:0] w);
    logic [WAYS-2:0] r;
    int n;
    r = b;
    n = int'(w) + WAYS - 1;
    for (int l = 0; l < LVL; l++) begin
      int p;
      p = (n - 1) / 2;
      r[NODE_W'(p)] = ((n % 2) == 1);
      n = p;
    end
    return r;
  endfunction

  always_comb begin
    int n;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      n = 2 * n + 1 + int'(st_q[q_set][NODE_W'(n)]);
    end
    victim = WAY_W'(n - (WAYS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= '0;
    end else begin
      if (hit_en) st_q[hit_set] <= touch(st_q[hit_set], hit_way);
      if (fill_en) begin
        if (hit_en && (hit_set == fill_set))
          st_q[fill_set] <= touch(touch(st_q[fill_set], hit_way), fill_way);
        else
          st_q[fill_set] <= touch(st_q[fill_set], fill_way);
      end
    end
  end

  // A cleared tree must steer every set's victim walk to way 0.
  p_clr_tree_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (victim == '0));
endmodule

// File: rtl/uop_cache.sv
module uop_cache
  import uc_pkg::*;
#(
  parameter int ADDR_W = UC_ADDR_W,
  parameter int SETS   = UC_SETS,
  parameter int WAYS   = UC_WAYS,
  parameter int NSLOT  = UC_NSLOT,
  parameter int UOP_W  = UC_UOP_W,
  parameter int OFS_W  = UC_OFS_W,
  parameter int LEN_W  = UC_LEN_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inv_all,
  input  logic                     lu_valid,
  input  logic [ADDR_W-1:0]        lu_addr,
  input  logic                     fill_valid,
  input  logic [ADDR_W-1:0]        fill_addr,
  input  logic [2:0]               fill_count,
  input  logic [NSLOT*UOP_W-1:0]   fill_uops,
  input  logic [NSLOT*OFS_W-1:0]   fill_start,
  input  logic [NSLOT*LEN_W-1:0]   fill_len,
  input  logic [NSLOT-1:0]         fill_ucode,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_fallback,
  output logic [NSLOT-1:0]         rsp_mask,
  output logic [NSLOT*UOP_W-1:0]   rsp_uops
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W;
  localparam int CNT_W = 3;
  localparam int PAY_W = NSLOT * UOP_W;
  localparam int ENT_W = IDX_W + WAY_W;
  localparam int ENTS  = SETS * WAYS;

  // Address split.
  logic [IDX_W-1:0] lu_set, fl_set;
  logic [TAG_W-1:0] lu_tag, fl_tag;
  assign lu_set = lu_addr[OFS_W +: IDX_W];
  assign fl_set = fill_addr[OFS_W +: IDX_W];
  assign lu_tag = lu_addr[ADDR_W-1 -: TAG_W];
  assign fl_tag = fill_addr[ADDR_W-1 -: TAG_W];

  // Storage: valid bits in resettable flops, the rest in plain arrays.
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0] tag_mem [ENTS];
  logic [CNT_W-1:0] cnt_mem [ENTS];
  logic [PAY_W-1:0] pay_mem [ENTS];

  logic [WAYS-1:0][TAG_W-1:0] lu_tags, fl_tags;
  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign lu_tags[w] = tag_mem[{lu_set, WAY_W'(w)}];
    assign fl_tags[w] = tag_mem[{fl_set, WAY_W'(w)}];
  end

  logic [WAYS-1:0]  lu_match, fl_match;
  logic             lu_hit, fl_hit;
  logic [WAY_W-1:0] lu_way, fl_hit_way;

  uc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lu_match (
    .vld(vld_q[lu_set]), .tags(lu_tags), .tag(lu_tag),
    .match(lu_match), .hit(lu_hit), .way(lu_way));

  uc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
    .vld(vld_q[fl_set]), .tags(fl_tags), .tag(fl_tag),
    .match(fl_match), .hit(fl_hit), .way(fl_hit_way));

  // Fill acceptance.
  logic fill_ok, fill_acc;
  uc_fill_screen #(.NSLOT(NSLOT), .OFS_W(OFS_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_screen (
    .cnt(fill_count), .start(fill_start), .len(fill_len), .ucode(fill_ucode), .ok(fill_ok));
  assign fill_acc = fill_valid && fill_ok && !inv_all;

  // Way choice for a fill.
  logic             free_any;
  logic [WAY_W-1:0] free_way, plru_way, fl_way;
  fill_src_e        fl_src;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[fl_set][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (fl_hit)        fl_src = FS_SAME;
    else if (free_any) fl_src = FS_FREE;
    else               fl_src = FS_PLRU;
    case (fl_src)
      FS_SAME: fl_way = fl_hit_way;
      FS_FREE: fl_way = free_way;
      default: fl_way = plru_way;
    endcase
  end

  uc_plru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_plru (
    .clk(clk), .rst(rst), .clr(inv_all),
    .hit_en(lu_valid && lu_hit && !inv_all), .hit_set(lu_set), .hit_way(lu_way),
    .fill_en(fill_acc), .fill_set(fl_set), .fill_way(fl_way),
    .q_set(fl_set), .victim(plru_way));

  // Writes.
  logic [ENT_W-1:0] fl_idx;
  assign fl_idx = {fl_set, fl_way};

  always_ff @(posedge clk) begin
    if (rst || inv_all) vld_q <= '0;
    else if (fill_acc)  vld_q[fl_set][fl_way] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_acc) begin
      tag_mem[fl_idx] <= fl_tag;
      cnt_mem[fl_idx] <= fill_count;
      pay_mem[fl_idx] <= fill_uops;
    end
  end

  // Read side and registered response.
  logic [ENT_W-1:0] hit_idx;
  logic [CNT_W-1:0] rd_cnt;
  logic [PAY_W-1:0] rd_pay;
  logic [NSLOT-1:0] nxt_mask;
  logic [PAY_W-1:0] nxt_uops;
  assign hit_idx = {lu_set, lu_way};
  assign rd_cnt  = cnt_mem[hit_idx];
  assign rd_pay  = pay_mem[hit_idx];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign nxt_mask[s] = lu_valid && lu_hit && (rd_cnt > CNT_W'(s));
    assign nxt_uops[s*UOP_W +: UOP_W] = nxt_mask[s] ? rd_pay[s*UOP_W +: UOP_W] : '0;
  end

  logic rsp_valid_q, rsp_hit_q, rsp_fb_q;
  logic [NSLOT-1:0] rsp_mask_q;
  logic [PAY_W-1:0] rsp_uops_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_fb_q    <= 1'b0;
      rsp_mask_q  <= '0;
      rsp_uops_q  <= '0;
    end else begin
      rsp_valid_q <= lu_valid;
      rsp_hit_q   <= lu_valid && lu_hit;
      rsp_fb_q    <= lu_valid && !lu_hit;
      rsp_mask_q  <= nxt_mask;
      rsp_uops_q  <= nxt_uops;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_hit      = rsp_hit_q;
  assign rsp_fallback = rsp_fb_q;
  assign rsp_mask     = rsp_mask_q;
  assign rsp_uops     = rsp_uops_q;

  // Checks kept beside the logic they guard.
  p_resp_next_r3: assert property (@(posedge clk) disable iff (rst)
    lu_valid |=> rsp_valid);
  p_resp_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid == (rsp_hit ^ rsp_fallback)) && !(rsp_hit && rsp_fallback));
  p_mask_contig_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_mask[0] && ((rsp_mask & (rsp_mask + 1'b1)) == '0)));
  p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> ((rsp_mask == '0) && (rsp_uops == '0)));
  p_no_dup_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lu_match) && $onehot0(fl_match));
  p_reject_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    !fill_acc |=> ((vld_q & ~$past(vld_q)) == '0));
  p_inv_clears_r10: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (vld_q == '0));
endmodule

// File: tb/tb_uop_cache.sv
`timescale 1ns/1ps
module tb_uop_cache;
  localparam int AW = 32, NS = 32, NW = 8, SL = 6, UW = 32, OW = 5, LW = 4, CW = 3;
  localparam int PW = SL * UW;
  localparam int TW = AW - 10;

  logic clk = 1'b0, rst = 1'b1, inv_all = 1'b0, lu_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] lu_addr = '0, fill_addr = '0;
  logic [CW-1:0] fill_count = '0;
  logic [PW-1:0] fill_uops = '0;
  logic [SL*OW-1:0] fill_start = '0;
  logic [SL*LW-1:0] fill_len = '0;
  logic [SL-1:0] fill_ucode = '0;
  logic rsp_valid, rsp_hit, rsp_fallback;
  logic [SL-1:0] rsp_mask;
  logic [PW-1:0] rsp_uops;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uop_cache dut (
    .clk(clk), .rst(rst), .inv_all(inv_all), .lu_valid(lu_valid), .lu_addr(lu_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_count(fill_count),
    .fill_uops(fill_uops), .fill_start(fill_start), .fill_len(fill_len),
    .fill_ucode(fill_ucode), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fallback(rsp_fallback), .rsp_mask(rsp_mask), .rsp_uops(rsp_uops));

  // ---------------- reference model ----------------
  bit            m_v   [NS][NW];
  logic [TW-1:0] m_tag [NS][NW];
  int            m_cnt [NS][NW];
  logic [PW-1:0] m_pay [NS][NW];
  logic [NW-2:0] m_lru [NS];
  logic          e_valid = 1'b0, e_hit = 1'b0;
  logic [SL-1:0] e_mask = '0;
  logic [PW-1:0] e_uops = '0;

  function automatic logic [NW-2:0] m_touch(logic [NW-2:0] b, int w);
    int n = w + NW - 1;
    while (n > 0) begin
      int p = (n - 1) / 2;
      b[p] = ((n % 2) == 1);
      n = p;
    end
    return b;
  endfunction

  function automatic int m_victim(logic [NW-2:0] b);
    int n = 0;
    while (n < NW - 1) n = 2 * n + 1 + int'(b[n]);
    return n - (NW - 1);
  endfunction

  function automatic bit m_fill_ok();
    int c = int'(fill_count);
    if (c < 1 || c > SL) return 1'b0;
    for (int s = 0; s < c; s++) begin
      int st = int'(fill_start[s*OW +: OW]);
      int ln = int'(fill_len[s*LW +: LW]);
      if (ln == 0 || st + ln >= 32 || fill_ucode[s]) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin : model
    int ls, fs, hw, fw;
    logic [TW-1:0] lt, ft;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        m_lru[i] = '0;
        for (int w = 0; w < NW; w++) m_v[i][w] = 1'b0;
      end
      e_valid = 1'b0; e_hit = 1'b0; e_mask = '0; e_uops = '0;
    end else begin
      ls = int'(lu_addr[9:5]);
      lt = lu_addr[AW-1:10];
      hw = -1;
      for (int w = 0; w < NW; w++) if (m_v[ls][w] && m_tag[ls][w] == lt) hw = w;
      e_valid = lu_valid;
      e_hit   = lu_valid && (hw >= 0);
      e_mask  = '0;
      e_uops  = '0;
      if (e_hit) begin
        for (int s = 0; s < m_cnt[ls][hw]; s++) begin
          e_mask[s] = 1'b1;
          e_uops[s*UW +: UW] = m_pay[ls][hw][s*UW +: UW];
        end
      end
      if (inv_all) begin
        for (int i = 0; i < NS; i++) begin
          m_lru[i] = '0;
          for (int w = 0; w < NW; w++) m_v[i][w] = 1'b0;
        end
      end else begin
        fw = -1;
        fs = int'(fill_addr[9:5]);
        ft = fill_addr[AW-1:10];
        if (fill_valid && m_fill_ok()) begin
          for (int w = 0; w < NW; w++) if (m_v[fs][w] && m_tag[fs][w] == ft) fw = w;
          if (fw < 0) for (int w = NW - 1; w >= 0; w--) if (!m_v[fs][w]) fw = w;
          if (fw < 0) fw = m_victim(m_lru[fs]);
        end
        if (e_hit) m_lru[ls] = m_touch(m_lru[ls], hw);
        if (fw >= 0) begin
          m_lru[fs] = m_touch(m_lru[fs], fw);
          m_v[fs][fw] = 1'b1;
          m_tag[fs][fw] = ft;
          m_cnt[fs][fw] = int'(fill_count);
          m_pay[fs][fw] = fill_uops;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_fallback !== (e_valid && !e_hit) ||
          rsp_mask !== e_mask || rsp_uops !== e_uops) begin
        errors++;
        $display("FAIL %s model: got v%0b h%0b f%0b m%h u%h expected v%0b h%0b f%0b m%h u%h",
                 phase, rsp_valid, rsp_hit, rsp_fallback, rsp_mask, rsp_uops,
                 e_valid, e_hit, e_valid && !e_hit, e_mask, e_uops);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int t, int s, int o);
    return {TW'(t), 5'(s), 5'(o)};
  endfunction

  // kind: 1 ends on byte 31, 2 crosses, 3 microcoded, 4 zero length, 5 ends on byte 30
  task automatic set_fill(input logic [AW-1:0] a, input int cnt, input int seed,
                          input int bad_slot, input int kind);
    fill_valid = 1'b1;
    fill_addr  = a;
    fill_count = CW'(cnt);
    fill_ucode = '0;
    for (int s = 0; s < SL; s++) begin
      fill_uops[s*UW +: UW]  = UW'(seed * 256 + s);
      fill_start[s*OW +: OW] = OW'(s * 4);
      fill_len[s*LW +: LW]   = LW'(4);
    end
    if (bad_slot >= 0) begin
      case (kind)
        1: begin fill_start[bad_slot*OW +: OW] = OW'(28); fill_len[bad_slot*LW +: LW] = LW'(4); end
        2: begin fill_start[bad_slot*OW +: OW] = OW'(30); fill_len[bad_slot*LW +: LW] = LW'(3); end
        3: fill_ucode[bad_slot] = 1'b1;
        4: fill_len[bad_slot*LW +: LW] = '0;
        default: begin fill_start[bad_slot*OW +: OW] = OW'(27); fill_len[bad_slot*LW +: LW] = LW'(4); end
      endcase
    end
  endtask

  task automatic set_lu(input logic [AW-1:0] a);
    lu_valid = 1'b1;
    lu_addr  = a;
  endtask

  task automatic step();
    @(negedge clk);
    fill_valid = 1'b0;
    lu_valid   = 1'b0;
    inv_all    = 1'b0;
  endtask

  task automatic look(input int t, input int s, input int o, input bit exp_hit, input string req);
    set_lu(mk(t, s, o));
    step();
    chk(rsp_hit == exp_hit, req, "hit", 64'(rsp_hit), 64'(exp_hit));
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    phase = "R1";
    chk(rsp_valid == 1'b0 && rsp_mask == '0, "R1", "reset outputs", 64'(rsp_valid), 64'(0));
    look(1, 0, 0, 1'b0, "R1");
    chk(rsp_fallback == 1'b1, "R1", "fallback", 64'(rsp_fallback), 64'(1));

    // R11 fill with concurrent lookup, R2 offset ignored, R4 payload
    phase = "R11";
    set_fill(mk(1, 0, 0), 3, 1, -1, 0);
    set_lu(mk(1, 0, 0));
    step();
    chk(rsp_hit == 1'b0, "R11", "same-cycle lookup", 64'(rsp_hit), 64'(0));
    phase = "R2";
    look(1, 0, 31, 1'b1, "R2");
    chk(rsp_mask == 6'b000111, "R4", "mask", 64'(rsp_mask), 64'(6'b000111));
    chk(rsp_uops[UW-1:0] == 32'd256, "R4", "slot0", 64'(rsp_uops[UW-1:0]), 64'(256));
    chk(rsp_uops[PW-1:3*UW] == '0, "R4", "unused slots", 64'(rsp_uops[4*UW-1:3*UW]), 64'(0));
    look(1, 1, 0, 1'b0, "R2");
    look(2, 0, 0, 1'b0, "R2");

    // R3 timing
    phase = "R3";
    set_lu(mk(1, 0, 4));
    set_fill(mk(3, 5, 0), 2, 3, -1, 0);
    step();
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b1, "R3", "next-cycle response", 64'(rsp_valid), 64'(1));
    step();
    chk(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_fallback == 1'b0, "R3", "idle response",
        64'(rsp_valid), 64'(0));

    // R5 chunk-edge screen
    phase = "R5";
    set_fill(mk(2, 1, 0), 4, 2, 3, 1); step(); look(2, 1, 0, 1'b0, "R5");
    set_fill(mk(2, 1, 0), 4, 2, 0, 2); step(); look(2, 1, 0, 1'b0, "R5");
    set_fill(mk(2, 1, 0), 4, 2, 3, 5); step(); look(2, 1, 0, 1'b1, "R5");

    // R6 microcode
    phase = "R6";
    set_fill(mk(4, 1, 0), 6, 4, 5, 3); step(); look(4, 1, 0, 1'b0, "R6");

    // R7 malformed fills and ignored slots
    phase = "R7";
    set_fill(mk(5, 2, 0), 0, 5, -1, 0); step(); look(5, 2, 0, 1'b0, "R7");
    set_fill(mk(5, 2, 0), 7, 5, -1, 0); step(); look(5, 2, 0, 1'b0, "R7");
    set_fill(mk(5, 2, 0), 3, 5, 1, 4);  step(); look(5, 2, 0, 1'b0, "R7");
    set_fill(mk(5, 2, 0), 2, 5, 4, 1);  step(); look(5, 2, 0, 1'b1, "R7");
    chk(rsp_mask == 6'b000011, "R7", "mask", 64'(rsp_mask), 64'(6'b000011));

    // R8 refill in place
    phase = "R8";
    set_fill(mk(1, 0, 0), 5, 9, -1, 0); step(); look(1, 0, 0, 1'b1, "R8");
    chk(rsp_uops[UW-1:0] == 32'(9 * 256), "R8", "new slot0", 64'(rsp_uops[UW-1:0]), 64'(9 * 256));
    chk(rsp_mask == 6'b011111, "R8", "new mask", 64'(rsp_mask), 64'(6'b011111));

    // R9 replacement
    phase = "R9";
    for (int t = 1; t <= 8; t++) begin set_fill(mk(t, 3, 0), 1, t, -1, 0); step(); end
    look(1, 3, 0, 1'b1, "R9");
    set_fill(mk(9, 3, 0), 1, 9, -1, 0); step();
    look(5, 3, 0, 1'b0, "R9");
    look(1, 3, 0, 1'b1, "R9");
    look(9, 3, 0, 1'b1, "R9");

    // R10 invalidate against concurrent fill and lookup
    phase = "R10";
    set_fill(mk(20, 4, 0), 2, 20, -1, 0);
    set_lu(mk(1, 0, 0));
    inv_all = 1'b1;
    step();
    chk(rsp_hit == 1'b1, "R10", "pre-clear lookup", 64'(rsp_hit), 64'(1));
    look(20, 4, 0, 1'b0, "R10");
    look(1, 0, 0, 1'b0, "R10");
    look(9, 3, 0, 1'b0, "R10");

    // mixed traffic against the model
    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 100) < 70)
        set_lu(mk(int'($urandom % 12), int'($urandom % 3), int'($urandom % 32)));
      if (($urandom % 100) < 40)
        set_fill(mk(int'($urandom % 12), int'($urandom % 3), 0), 1 + int'($urandom % 6), i,
                 (($urandom % 4) == 0) ? int'($urandom % 6) : -1, 1 + int'($urandom % 5));
      if (($urandom % 200) == 0) inv_all = 1'b1;
      step();
    end

    step();
    done = 1'b1;
    finish_up();
  end
endmodule